// File: doc/BRIEF.md
# Fetch-Stage Branch Predictor with Target Cache

This block sits beside the fetch address register of an in-order pipeline. Every cycle it takes the current fetch address, looks it up in two direct-mapped tables that share one index, and one cycle later reports three things: whether the branch at that address is expected to be taken, whether the target cache holds a matching entry, and the address fetch should go to next. When the branch is expected to be taken and the target cache holds its destination, fetch is steered straight to that destination. In every other case the next address is the current address plus four.

The direction table holds one four-state hysteresis counter per entry. A branch must move its counter by two steps before a strong opinion changes. The target cache holds a valid flag, an address tag and a destination per entry. It is filled only by branches that resolved taken. A separate training port is driven when a branch resolves later in the pipeline. It moves the counter for that address and, for a taken outcome, writes the destination into the target cache.

Top module: `fetch_predictor`

## Requirements
- R1: A synchronous active-high reset sets every counter to weakly-not-taken (binary 01) and clears every target cache valid flag. The first result after reset is prediction 0, hit 0 and next address 4.
- R2: Both tables use fetch address bits [IDX_W+1:2] as the index, so address bits [1:0] have no effect on a lookup. The tag is made of bits [PC_W-1:IDX_W+2].
- R3: A taken training update moves the counter up one step (00→01→10→11) and holds it at 11.
- R4: A not-taken training update moves the counter down one step and holds it at 00.
- R5: The reported prediction is counter bit 1, so the prediction is taken for states 10 and 11. From a strong state, a single opposite outcome leaves the prediction unchanged.
- R6: If the prediction is not taken, or the target cache misses, the next address is the looked-up address plus 4. This applies even when the target cache hits.
- R7: A taken update writes valid=1, the tag and the destination into the entry at its index. A not-taken update leaves the target cache unchanged and does not create an entry.
- R8: A target cache hit requires both the valid flag and an exact tag match. An address that shares an index with the stored entry but has a different tag misses, although it still uses the shared counter.
- R9: When the prediction is taken and the target cache hits, the next address is the stored destination.
- R10: Results are due one cycle after the fetch address is sampled. A lookup sampled on the same edge as an update to the same entry sees the contents from before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pc_i | input | PC_W | Fetch address to look up |
| upd_valid_i | input | 1 | Training update strobe |
| upd_pc_i | input | PC_W | Address of the resolved branch |
| upd_taken_i | input | 1 | Resolved outcome, 1 = taken |
| upd_target_i | input | PC_W | Resolved destination of the branch |
| pred_taken_o | output | 1 | Predicted direction for the last sampled address |
| btb_hit_o | output | 1 | Target cache holds a valid entry with a matching tag |
| next_pc_o | output | PC_W | Next fetch address |

## Verification
A lookup is presented on a falling edge and sampled on the rising edge that follows. Its three results are due on that edge and stay stable until the next one, so the bench compares them on the next falling edge, before it drives anything new. A training update written on a rising edge first becomes visible to a lookup sampled on the rising edge after it. For that reason every update in the bench takes a full cycle, and only then is the lookup that depends on it presented. The collision case drives a lookup and an update to the same entry on the same falling edge. It expects the results from before the update on the first compare and the trained results on the lookup that follows.

// File: rtl/bpred_pkg.sv
`timescale 1ns/1ps
package bpred_pkg;

  typedef enum logic [1:0] {
    CTR_SNT = 2'b00,
    CTR_WNT = 2'b01,
    CTR_WT  = 2'b10,
    CTR_ST  = 2'b11
  } ctr_e;

  // Saturating step of the hysteresis counter
  function automatic ctr_e ctr_step(input ctr_e cur, input logic taken);
    ctr_e nxt;
    nxt = cur;
    if (taken && cur != CTR_ST)
      nxt = ctr_e'(cur + 2'd1);
    else if (!taken && cur != CTR_SNT)
      nxt = ctr_e'(cur - 2'd1);
    return nxt;
  endfunction

endpackage

// File: rtl/bht_counters.sv
`timescale 1ns/1ps
module bht_counters
  import bpred_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr_e             rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);
  localparam int DEPTH = 1 << IDX_W;

  ctr_e ctr_q [DEPTH];

  // Counters need a reset value, so they live in flops
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) ctr_q[i] <= CTR_WNT;
    end else if (wr_en) begin
      ctr_q[wr_idx] <= ctr_step(ctr_q[wr_idx], wr_taken);
    end
  end

  // Registered read, old data on a same-edge write
  always_ff @(posedge clk) begin
    if (rst) rd_ctr <= CTR_WNT;
    else     rd_ctr <= ctr_q[rd_idx];
  end

  p_sat_hi_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_taken && ctr_q[wr_idx] == CTR_ST) |=> ctr_q[$past(wr_idx)] == CTR_ST);

  p_sat_lo_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_taken && ctr_q[wr_idx] == CTR_SNT) |=> ctr_q[$past(wr_idx)] == CTR_SNT);

  p_one_step_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && ctr_q[wr_idx] == CTR_ST) |=> ctr_q[$past(wr_idx)][1]);

endmodule

// File: rtl/btb_table.sv
`timescale 1ns/1ps
module btb_table #(
  parameter int IDX_W = 6,
  parameter int TAG_W = 24,
  parameter int PC_W  = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag,
  output logic [PC_W-1:0]  rd_target,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [PC_W-1:0]  wr_target
);
  localparam int DEPTH = 1 << IDX_W;

  logic             vld_q [DEPTH];
  logic [TAG_W-1:0] tag_mem [DEPTH];
  logic [PC_W-1:0]  tgt_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) vld_q[i] <= 1'b0;
    end else if (wr_en) begin
      vld_q[wr_idx] <= 1'b1;
    end
  end

  // No reset on payload: fits a RAM with a registered read port
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx] <= wr_tag;
      tgt_mem[wr_idx] <= wr_target;
    end
    rd_tag    <= tag_mem[rd_idx];
    rd_target <= tgt_mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) rd_valid <= 1'b0;
    else     rd_valid <= vld_q[rd_idx];
  end

  p_fill_valid_r7: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> vld_q[$past(wr_idx)]);

endmodule

// File: rtl/fetch_predictor.sv
`timescale 1ns/1ps
module fetch_predictor
  import bpred_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] pc_i,
  input  logic            upd_valid_i,
  input  logic [PC_W-1:0] upd_pc_i,
  input  logic            upd_taken_i,
  input  logic [PC_W-1:0] upd_target_i,
  output logic            pred_taken_o,
  output logic            btb_hit_o,
  output logic [PC_W-1:0] next_pc_o
);
  localparam int TAG_W = PC_W - IDX_W - 2;

  logic [IDX_W-1:0] rd_idx, wr_idx;
  logic [TAG_W-1:0] wr_tag, rd_tag;
  logic [PC_W-1:0]  pc_q, rd_target;
  logic             rd_valid;
  ctr_e             rd_ctr;
  logic             unused_lo;

  assign rd_idx    = pc_i[IDX_W+1:2];
  assign wr_idx    = upd_pc_i[IDX_W+1:2];
  assign wr_tag    = upd_pc_i[PC_W-1:IDX_W+2];
  assign unused_lo = ^upd_pc_i[1:0];

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_i;
  end

  bht_counters #(.IDX_W(IDX_W)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .rd_idx   (rd_idx),
    .rd_ctr   (rd_ctr),
    .wr_en    (upd_valid_i),
    .wr_idx   (wr_idx),
    .wr_taken (upd_taken_i)
  );

  btb_table #(.IDX_W(IDX_W), .TAG_W(TAG_W), .PC_W(PC_W)) u_btb (
    .clk       (clk),
    .rst       (rst),
    .rd_idx    (rd_idx),
    .rd_valid  (rd_valid),
    .rd_tag    (rd_tag),
    .rd_target (rd_target),
    .wr_en     (upd_valid_i && upd_taken_i),
    .wr_idx    (wr_idx),
    .wr_tag    (wr_tag),
    .wr_target (upd_target_i)
  );

  always_comb begin
    pred_taken_o = rd_ctr[1];
    btb_hit_o    = rd_valid && (rd_tag == pc_q[PC_W-1:IDX_W+2]);
    next_pc_o    = (pred_taken_o && btb_hit_o) ? rd_target : pc_q + PC_W'(4);
  end

  p_fallthru_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !(pred_taken_o && btb_hit_o)) |-> next_pc_o == $past(pc_i) + PC_W'(4));

  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (!btb_hit_o && !pred_taken_o));

endmodule

// File: tb/fetch_predictor_test.sv
`timescale 1ns/1ps
module fetch_predictor_test;
  localparam int PC_W  = 32;
  localparam int IDX_W = 6;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [PC_W-1:0] pc_i = '0;
  logic            upd_valid_i = 1'b0;
  logic [PC_W-1:0] upd_pc_i = '0;
  logic            upd_taken_i = 1'b0;
  logic [PC_W-1:0] upd_target_i = '0;
  logic            pred_taken_o, btb_hit_o;
  logic [PC_W-1:0] next_pc_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  fetch_predictor #(.PC_W(PC_W), .IDX_W(IDX_W)) uut (
    .clk(clk), .rst(rst), .pc_i(pc_i),
    .upd_valid_i(upd_valid_i), .upd_pc_i(upd_pc_i),
    .upd_taken_i(upd_taken_i), .upd_target_i(upd_target_i),
    .pred_taken_o(pred_taken_o), .btb_hit_o(btb_hit_o), .next_pc_o(next_pc_o)
  );

  typedef struct packed {
    logic        look;
    logic [31:0] pc;
    logic        tk;
    logic [31:0] tgt;
    logic        et;
    logic        eh;
    logic [31:0] en;
    logic [23:0] rq;
  } vec_t;

  localparam int NV = 24;
  // A=0x1010 idx 4 tag 0x10; B=0x1110 same idx, tag 0x11; C=0x20 idx 8; D=0x40 idx 16
  localparam vec_t VECS [NV] = '{
    '{1'b1, 32'h1010, 1'b0, 32'h0,    1'b0, 1'b0, 32'h1014, "R1"},
    '{1'b0, 32'h1010, 1'b1, 32'h2000, 1'b0, 1'b0, 32'h0,    "R7"},
    '{1'b1, 32'h1010, 1'b0, 32'h0,    1'b1, 1'b1, 32'h2000, "R9"},
    '{1'b1, 32'h1011, 1'b0, 32'h0,    1'b1, 1'b1, 32'h2000, "R2"},
    '{1'b0, 32'h1010, 1'b1, 32'h2000, 1'b0, 1'b0, 32'h0,    "R3"},
    '{1'b0, 32'h1010, 1'b1, 32'h2000, 1'b0, 1'b0, 32'h0,    "R3"},
    '{1'b0, 32'h1010, 1'b0, 32'h0,    1'b0, 1'b0, 32'h0,    "R5"},
    '{1'b1, 32'h1010, 1'b0, 32'h0,    1'b1, 1'b1, 32'h2000, "R5"},
    '{1'b0, 32'h1010, 1'b0, 32'h0,    1'b0, 1'b0, 32'h0,    "R4"},
    '{1'b1, 32'h1010, 1'b0, 32'h0,    1'b0, 1'b1, 32'h1014, "R7"},
    '{1'b0, 32'h1010, 1'b0, 32'h0,    1'b0, 1'b0, 32'h0,    "R4"},
    '{1'b0, 32'h1010, 1'b0, 32'h0,    1'b0, 1'b0, 32'h0,    "R4"},
    '{1'b1, 32'h1010, 1'b0, 32'h0,    1'b0, 1'b1, 32'h1014, "R4"},
    '{1'b0, 32'h1010, 1'b1, 32'h2000, 1'b0, 1'b0, 32'h0,    "R3"},
    '{1'b1, 32'h1010, 1'b0, 32'h0,    1'b0, 1'b1, 32'h1014, "R4"},
    '{1'b0, 32'h1010, 1'b1, 32'h2000, 1'b0, 1'b0, 32'h0,    "R3"},
    '{1'b1, 32'h1010, 1'b0, 32'h0,    1'b1, 1'b1, 32'h2000, "R5"},
    '{1'b1, 32'h1110, 1'b0, 32'h0,    1'b1, 1'b0, 32'h1114, "R8"},
    '{1'b0, 32'h1110, 1'b1, 32'h3000, 1'b0, 1'b0, 32'h0,    "R7"},
    '{1'b1, 32'h1010, 1'b0, 32'h0,    1'b1, 1'b0, 32'h1014, "R6"},
    '{1'b1, 32'h1110, 1'b0, 32'h0,    1'b1, 1'b1, 32'h3000, "R9"},
    '{1'b1, 32'h0020, 1'b0, 32'h0,    1'b0, 1'b0, 32'h0024, "R1"},
    '{1'b0, 32'h0040, 1'b0, 32'h0,    1'b0, 1'b0, 32'h0,    "R7"},
    '{1'b1, 32'h0040, 1'b0, 32'h0,    1'b0, 1'b0, 32'h0044, "R7"}
  };

  task automatic compare(input logic et, input logic eh, input logic [31:0] en,
                         input logic [23:0] rq);
    n_chk++;
    if (pred_taken_o !== et || btb_hit_o !== eh || next_pc_o !== en) begin
      n_bad++;
      $display("FAIL %s: got taken=%0b hit=%0b next=%h, expected taken=%0b hit=%0b next=%h",
               rq, pred_taken_o, btb_hit_o, next_pc_o, et, eh, en);
    end
  endtask

  task automatic train(input logic [31:0] pc, input logic tk, input logic [31:0] tgt);
    @(negedge clk);
    upd_valid_i = 1'b1; upd_pc_i = pc; upd_taken_i = tk; upd_target_i = tgt;
    @(negedge clk);
    upd_valid_i = 1'b0;
  endtask

  task automatic lookup(input logic [31:0] pc, input logic et, input logic eh,
                        input logic [31:0] en, input logic [23:0] rq);
    @(negedge clk);
    pc_i = pc;
    @(negedge clk);
    compare(et, eh, en, rq);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got no finish, expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // Reset state: pc register cleared, so next address is 4 (R1)
    compare(1'b0, 1'b0, 32'h4, "R1");

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].look) lookup(VECS[i].pc, VECS[i].et, VECS[i].eh, VECS[i].en, VECS[i].rq);
      else              train(VECS[i].pc, VECS[i].tk, VECS[i].tgt);
    end

    // R10: lookup and update of C sampled on the same edge, old contents seen
    @(negedge clk);
    pc_i = 32'h20;
    upd_valid_i = 1'b1; upd_pc_i = 32'h20; upd_taken_i = 1'b1; upd_target_i = 32'h4000;
    @(negedge clk);
    upd_valid_i = 1'b0;
    compare(1'b0, 1'b0, 32'h24, "R10");
    // Update of C now visible (01 -> 10, entry filled)
    lookup(32'h20, 1'b1, 1'b1, 32'h4000, "R10");

    // R1: reset mid-run clears trained state
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    compare(1'b0, 1'b0, 32'h4, "R1");
    lookup(32'h1010, 1'b0, 1'b0, 32'h1014, "R1");
    lookup(32'h20, 1'b0, 1'b0, 32'h24, "R1");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule